// File: doc/BRIEF.md
# Programmable Horizontal Sync Generator

The block watches an 8-bit digital component video byte stream, of the kind that carries embedded timing reference codes, one byte per pixel-bus clock. When it sees the four-byte end-of-active-video code, it restarts a pixel position counter. It then drives a horizontal sync output whose leading and trailing edges fall at two programmable 11-bit positions on that counter. The counter also runs freely and wraps at the line length of the selected video standard, so the sync output keeps going when reference codes are missing.

Software loads the two edge positions and an output polarity bit through a byte-wide write port. Both edge positions are reduced modulo the line length. The pulse may therefore straddle the end of the line. Adding the same amount to both edges moves the pulse toward active video, and adding the line length minus N to both moves it N clocks away. Edge writes go to a staging copy and take effect only when the counter restarts, so a line never uses a half-written pair. The polarity bit takes effect on the next clock.

Top module: `hsync_gen`

## Requirements
- R1: After synchronous reset, `pix_count` is 0, the polarity bit is 0, and `hs_out` is low. The leading offset is 2 and the trailing offset is 0, both in the active and in the staging copy.
- R2: An end-of-active-video code is the bytes 0xFF, 0x00, 0x00 followed by a fourth byte with bit 4 set. `pix_count` reads 0 in the cycle after that fourth byte. When the fourth byte has bit 4 clear (start-of-active-video code), the counter is not affected.
- R3: The code matcher restarts on a partial match. For example, 0xFF, 0xFF, 0x00, 0x00, 0x9D is detected.
- R4: With no code present, `pix_count` goes up by 1 each clock and returns to 0 after reaching line length minus 1.
- R5: `std_sel` sets the line length: 00 gives 1716, 01 gives 1560, 10 gives 1728, and 11 gives 1716.
- R6: With polarity 0, `hs_out` is high exactly while `pix_count` is at or after the leading offset and before the trailing offset. When the leading offset is larger, the window wraps through count 0.
- R7: When the two offsets are equal after reduction, the sync is never asserted.
- R8: Each offset is taken modulo the selected line length before it is compared.
- R9: Polarity is bit 7 at address 0x37, and a value of 1 inverts `hs_out` (active low). The change shows in the cycle after the write.
- R10: Write map: 0x34 bits [6:4] hold leading[10:8] and bits [2:0] hold trailing[10:8]; 0x35 holds leading[7:0]; 0x36 holds trailing[7:0]. A write to any other address has no effect.
- R11: Offset writes reach the active copy only at a counter restart, whether from a code or from a wrap. The line in progress keeps its old window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_byte | input | 8 | Video byte stream |
| std_sel | input | 2 | Video standard select (line length) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| hs_out | output | 1 | Horizontal sync output |
| pix_count | output | 11 | Current pixel position in the line |

## Verification
If the matcher state is wrong, a code is missed or a spurious one is found. `pix_count` then fails to show 0 one clock after the code's last byte, or drops to 0 where it should not. If the counter or the edge registers are wrong, the `hs_out` edges move to the wrong positions, and the error shows within one line. This is at most 1728 clocks, and it shows at once in the cycle the bad position is compared. If staging is faulty, the new window appears before the line in progress has finished.

// File: rtl/hsg_pkg.sv
package hsg_pkg;
    localparam int OFS_W  = 11;
    localparam int BYTE_W = 8;
    localparam int HI_W   = OFS_W - BYTE_W;

    typedef logic [OFS_W-1:0]  pos_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        STD_525    = 2'b00,
        STD_525_SQ = 2'b01,
        STD_625    = 2'b10,
        STD_RSV    = 2'b11
    } std_e;

    typedef enum logic [1:0] {
        M_IDLE,
        M_FF,
        M_Z1,
        M_Z2
    } match_e;

    typedef struct packed {
        pos_t lead;
        pos_t trail;
    } edges_t;

    localparam int LEN_525    = 1716;
    localparam int LEN_525_SQ = 1560;
    localparam int LEN_625    = 1728;

    localparam byte_t ADR_HIGH   = 8'h34;
    localparam byte_t ADR_LEAD   = 8'h35;
    localparam byte_t ADR_TRAIL  = 8'h36;
    localparam byte_t ADR_POL    = 8'h37;

    localparam pos_t  LEAD_RST   = pos_t'(2);
    localparam pos_t  TRAIL_RST  = pos_t'(0);
    localparam int    XY_EAV_BIT = 4;
    localparam int    POL_BIT    = 7;

    function automatic pos_t line_len(std_e s);
        case (s)
            STD_525_SQ: return pos_t'(LEN_525_SQ);
            STD_625:    return pos_t'(LEN_625);
            default:    return pos_t'(LEN_525);
        endcase
    endfunction

    // Offsets never exceed 2^OFS_W - 1 < 2 * shortest line, so one subtract suffices.
    function automatic pos_t wrap_ofs(pos_t v, pos_t len);
        return (v >= len) ? pos_t'(v - len) : v;
    endfunction
endpackage

// File: rtl/hsg_eav_match.sv
module hsg_eav_match
    import hsg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  byte_t bus_byte,
    output logic  eav_hit
);
    match_e st_q, st_d;
    logic   is_ff, is_zero;

    assign is_ff   = (bus_byte == 8'hFF);
    assign is_zero = (bus_byte == 8'h00);

    always_comb begin
        eav_hit = 1'b0;
        st_d    = M_IDLE;
        case (st_q)
            M_IDLE: st_d = is_ff ? M_FF : M_IDLE;
            M_FF:   st_d = is_zero ? M_Z1 : (is_ff ? M_FF : M_IDLE);
            M_Z1:   st_d = is_zero ? M_Z2 : (is_ff ? M_FF : M_IDLE);
            M_Z2: begin
                eav_hit = bus_byte[XY_EAV_BIT];
                st_d    = is_ff ? M_FF : M_IDLE;
            end
            default: st_d = M_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= M_IDLE;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/hsg_line_ctr.sv
module hsg_line_ctr
    import hsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] std_sel,
    input  logic       eav_hit,
    output pos_t       pix_count,
    output pos_t       len,
    output logic       restart
);
    pos_t pix_q;
    logic at_end;

    assign len       = line_len(std_e'(std_sel));
    assign at_end    = (pix_q >= len - 1'b1);
    assign restart   = eav_hit | at_end;
    assign pix_count = pix_q;

    always_ff @(posedge clk) begin
        if (rst)          pix_q <= '0;
        else if (restart) pix_q <= '0;
        else              pix_q <= pix_q + 1'b1;
    end
endmodule

// File: rtl/hsg_regs.sv
module hsg_regs
    import hsg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  byte_t  wr_addr,
    input  byte_t  wr_data,
    input  logic   load,
    output edges_t act_edges,
    output logic   pol
);
    edges_t stage_q, act_q;
    logic   pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '{lead: LEAD_RST, trail: TRAIL_RST};
            act_q   <= '{lead: LEAD_RST, trail: TRAIL_RST};
            pol_q   <= 1'b0;
        end else begin
            if (load) act_q <= stage_q;
            if (wr_en) begin
                case (wr_addr)
                    ADR_HIGH: begin
                        stage_q.lead[OFS_W-1:BYTE_W]  <= wr_data[4+HI_W-1:4];
                        stage_q.trail[OFS_W-1:BYTE_W] <= wr_data[HI_W-1:0];
                    end
                    ADR_LEAD:  stage_q.lead[BYTE_W-1:0]  <= wr_data;
                    ADR_TRAIL: stage_q.trail[BYTE_W-1:0] <= wr_data;
                    ADR_POL:   pol_q <= wr_data[POL_BIT];
                    default: ;
                endcase
            end
        end
    end

    assign act_edges = act_q;
    assign pol       = pol_q;
endmodule

// File: rtl/hsg_window.sv
module hsg_window
    import hsg_pkg::*;
(
    input  pos_t   pix_count,
    input  pos_t   len,
    input  edges_t edges,
    input  logic   pol,
    output logic   hs_active,
    output logic   hs_out
);
    pos_t lead_m, trail_m;

    assign lead_m  = wrap_ofs(edges.lead, len);
    assign trail_m = wrap_ofs(edges.trail, len);

    always_comb begin
        if (lead_m == trail_m)
            hs_active = 1'b0;
        else if (lead_m < trail_m)
            hs_active = (pix_count >= lead_m) && (pix_count < trail_m);
        else
            hs_active = (pix_count >= lead_m) || (pix_count < trail_m);
    end

    assign hs_out = hs_active ^ pol;
endmodule

// File: rtl/hsync_gen.sv
module hsync_gen
    import hsg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_byte,
    input  logic [1:0]  std_sel,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [7:0]  wr_data,
    output logic        hs_out,
    output logic [10:0] pix_count
);
    logic   eav_hit;
    logic   restart;
    logic   pol;
    logic   hs_active;
    pos_t   len;
    pos_t   pix_q;
    edges_t act_edges;

    hsg_eav_match u_match (
        .clk      (clk),
        .rst      (rst),
        .bus_byte (bus_byte),
        .eav_hit  (eav_hit)
    );

    hsg_line_ctr u_ctr (
        .clk       (clk),
        .rst       (rst),
        .std_sel   (std_sel),
        .eav_hit   (eav_hit),
        .pix_count (pix_q),
        .len       (len),
        .restart   (restart)
    );

    hsg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .load      (restart),
        .act_edges (act_edges),
        .pol       (pol)
    );

    hsg_window u_win (
        .pix_count (pix_q),
        .len       (len),
        .edges     (act_edges),
        .pol       (pol),
        .hs_active (hs_active),
        .hs_out    (hs_out)
    );

    assign pix_count = pix_q;
endmodule

// File: rtl/hsync_gen_chk.sv
module hsync_gen_chk
    import hsg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       eav_hit,
    input logic       restart,
    input logic [1:0] std_sel,
    input pos_t       pix_q,
    input edges_t     act_edges,
    input logic       pol,
    input logic       hs_active,
    input logic       hs_out
);
    // R2: a detected code restarts the count on the next cycle
    a_r2_eav_restart: assert property (@(posedge clk) disable iff (rst)
        eav_hit |=> (pix_q == '0));

    // R4: free-running step when no code and not at line end
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (!eav_hit && (pix_q < line_len(std_e'(std_sel)) - 1'b1))
        |=> (pix_q == $past(pix_q) + 1'b1));

    // R5: count never leaves the longest supported line
    a_r5_bound: assert property (@(posedge clk) disable iff (rst)
        pix_q < pos_t'(LEN_625));

    // R7: equal edges keep the window closed
    a_r7_equal_closed: assert property (@(posedge clk) disable iff (rst)
        (act_edges.lead == act_edges.trail) |-> !hs_active);

    // R11: active edges only change at a restart
    a_r11_staged: assert property (@(posedge clk) disable iff (rst)
        !restart |=> $stable(act_edges));

    // R9: polarity flip toggles the pin when the window holds still
    a_r9_pol_flip: assert property (@(posedge clk) disable iff (rst)
        ($rose(pol) && $stable(hs_active)) |-> (hs_out != $past(hs_out)));
endmodule

bind hsync_gen hsync_gen_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .eav_hit   (eav_hit),
    .restart   (restart),
    .std_sel   (std_sel),
    .pix_q     (pix_q),
    .act_edges (act_edges),
    .pol       (pol),
    .hs_active (hs_active),
    .hs_out    (hs_out)
);

// File: tb/hsync_gen_tb_top.sv
module hsync_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_byte = 8'h10;
    logic [1:0]  std_sel = 2'b00;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic        hs_out;
    logic [10:0] pix_count;

    always #4 clk = ~clk;

    hsync_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_byte  (bus_byte),
        .std_sel   (std_sel),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .hs_out    (hs_out),
        .pix_count (pix_count)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // Reference model built from the requirements
    int m_pos = 0;
    int s_lead = 2, s_trail = 0;
    int a_lead = 2, a_trail = 0;
    int m_pol = 0;
    bit xy_now = 1'b0;

    function automatic int std_len(logic [1:0] s);
        case (s)
            2'b01:   return 1560;
            2'b10:   return 1728;
            default: return 1716;
        endcase
    endfunction

    function automatic int exp_hs();
        int len = std_len(std_sel);
        int b = a_lead % len;
        int e = a_trail % len;
        int w;
        if (b == e)     w = 0;
        else if (b < e) w = (m_pos >= b && m_pos < e) ? 1 : 0;
        else            w = (m_pos >= b || m_pos < e) ? 1 : 0;
        return w ^ m_pol;
    endfunction

    task automatic check_now();
        int eh = exp_hs();
        n_cmp++;
        if (int'(pix_count) != m_pos) begin
            n_bad++;
            $display("FAIL %s pix_count actual=%0d expected=%0d", tag, pix_count, m_pos);
        end
        n_cmp++;
        if (int'(hs_out) != eh) begin
            n_bad++;
            $display("FAIL %s hs_out at pos %0d actual=%0d expected=%0d", tag, m_pos, hs_out, eh);
        end
    endtask

    task automatic step();
        int len;
        bit ld;
        @(posedge clk);
        len = std_len(std_sel);
        ld = xy_now || (m_pos >= len - 1);
        m_pos = ld ? 0 : m_pos + 1;
        if (ld) begin
            a_lead  = s_lead;
            a_trail = s_trail;
        end
        if (wr_en) begin
            case (wr_addr)
                8'h34: begin
                    s_lead  = (s_lead & 255)  | (int'(wr_data[6:4]) << 8);
                    s_trail = (s_trail & 255) | (int'(wr_data[2:0]) << 8);
                end
                8'h35: s_lead  = (s_lead & 1792)  | int'(wr_data);
                8'h36: s_trail = (s_trail & 1792) | int'(wr_data);
                8'h37: m_pol   = int'(wr_data[7]);
                default: ;
            endcase
        end
        @(negedge clk);
        check_now();
    endtask

    task automatic walk(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic send(logic [7:0] b, bit is_eav);
        bus_byte = b;
        xy_now = is_eav;
        step();
        xy_now = 1'b0;
        bus_byte = 8'h10;
    endtask

    task automatic eav();
        send(8'hFF, 1'b0);
        send(8'h00, 1'b0);
        send(8'h00, 1'b0);
        send(8'h9D, 1'b1);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic set_edges(int lead, int trail);
        wr(8'h34, 8'((((lead >> 8) & 7) << 4) | ((trail >> 8) & 7)));
        wr(8'h35, 8'(lead & 255));
        wr(8'h36, 8'(trail & 255));
    endtask

    // R1: reset state
    task automatic t_reset();
        tag = "R1";
        check_now();
        walk(5);
    endtask

    // R2: end code restarts; start code with bit 4 clear is ignored
    task automatic t_eav_sav();
        tag = "R2";
        walk(37);
        eav();
        walk(50);
        send(8'hFF, 1'b0); send(8'h00, 1'b0); send(8'h00, 1'b0); send(8'h80, 1'b0);
        walk(20);
    endtask

    // R3: partial match restarts cleanly
    task automatic t_partial();
        tag = "R3";
        walk(11);
        send(8'hFF, 1'b0);
        eav();
        walk(10);
        send(8'hFF, 1'b0); send(8'h00, 1'b0); send(8'hFF, 1'b0);
        send(8'h00, 1'b0); send(8'h00, 1'b0); send(8'hB6, 1'b1);
        walk(10);
    endtask

    // R4 + R6 defaults: a full free-running line with the reset window
    task automatic t_wrap();
        tag = "R4";
        eav();
        walk(1716 + 12);
    endtask

    // R5: line length per standard
    task automatic t_std();
        tag = "R5";
        std_sel = 2'b01; eav(); walk(1560 + 5);
        std_sel = 2'b10; eav(); walk(1728 + 5);
        std_sel = 2'b11; eav(); walk(1716 + 5);
        std_sel = 2'b00; eav();
    endtask

    // R6: plain and wrapping windows, plus the shift-by-twenty cases
    task automatic t_window();
        tag = "R6";
        set_edges(10, 20); eav(); walk(40);
        set_edges(1710, 5); eav(); walk(1716 + 10);
        set_edges(22, 20); eav(); walk(1716 + 4);
        set_edges(1698, 1696); eav(); walk(1716 + 4);
    endtask

    // R7: equal edges never assert
    task automatic t_equal();
        tag = "R7";
        set_edges(100, 100); eav(); walk(1716 + 4);
    endtask

    // R8: offsets beyond the line length wrap
    task automatic t_modulo();
        tag = "R8";
        set_edges(1720, 1730); eav(); walk(30);
        std_sel = 2'b01;
        set_edges(1570, 1565); eav(); walk(1560 + 4);
        std_sel = 2'b00; eav();
    endtask

    // R9: polarity inversion, next cycle
    task automatic t_pol();
        tag = "R9";
        set_edges(10, 20); eav(); walk(12);
        wr(8'h37, 8'h80); walk(20);
        wr(8'h37, 8'h7F); walk(5);
    endtask

    // R10: writes to unmapped addresses change nothing
    task automatic t_map();
        tag = "R10";
        set_edges(300, 310);
        wr(8'h38, 8'hFF); wr(8'h33, 8'hFF); wr(8'h00, 8'hAA);
        eav(); walk(320);
    endtask

    // R11: a write mid-line waits for the restart
    task automatic t_staged();
        tag = "R11";
        set_edges(10, 20); eav(); walk(5);
        set_edges(40, 50);
        walk(60);
        eav(); walk(60);
        set_edges(5, 8);
        walk(1716);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_eav_sav();
        t_partial();
        t_wrap();
        t_std();
        t_window();
        t_equal();
        t_modulo();
        t_pol();
        t_map();
        t_staged();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL %s watchdog actual=timeout expected=completion", tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule